// File: doc/BRIEF.md
# BCD Seven-Segment Latching Decoder

This block converts a four-bit binary-coded decimal digit into seven active-high segment drives for a common-cathode display. The segments are labelled a to g. A digit register sits in front of the decoder and is controlled by an active-low capture input. While capture is low, the display follows the live digit. While capture is high, the display shows the digit that was taken at the last clock edge where capture was low.

Two active-low override inputs act only on the outputs. Lamp test lights every segment. Blanking darkens every segment. Lamp test wins over blanking. Neither override ever changes the stored digit. Input codes from ten to fifteen give a dark display.

The design is fully synchronous. A rising clock edge and a synchronous active-high reset take the place of a level-sensitive latch.

Top module: `bcd7_decoder`

## Requirements
- R1: While `captureN` is 0, `segOut` shows the decode of the live `digitIn` in the same cycle, with no clock edge needed.
- R2: At every rising edge where `captureN` is 0, the register takes `digitIn`. While `captureN` is 1, `segOut` shows the decode of the digit taken at the last such edge, and changes on `digitIn` have no effect.
- R3: While `lampTestN` is 0, all seven bits of `segOut` are 1, whatever the other inputs are.
- R4: While `lampTestN` is 1 and `blankN` is 0, all seven bits of `segOut` are 0.
- R5: Neither override changes the stored digit. When both overrides are released, `segOut` shows the decode of the held digit again.
- R6: Codes 10 to 15 give `segOut` = 7'h00.
- R7: `segOut` bit 0 drives segment a, and bits 1 to 6 drive b to g in that order. The lit segments per digit are:
  - 0: a b c d e f (7'h3F)
  - 1: b c (7'h06)
  - 2: a b d e g (7'h5B)
  - 3: a b c d g (7'h4F)
  - 4: b c f g (7'h66)
  - 5: a c d f g (7'h6D)
  - 6: c d e f g (7'h7C)
  - 7: a b c (7'h07)
  - 8: all seven (7'h7F)
  - 9: a b c f g (7'h67)
- R8: A rising edge with `rst` at 1 clears the stored digit to 0. With `captureN` at 1 after reset, `segOut` reads 7'h3F.
- R9: The bits of `digitIn` carry weights 1, 2, 4 and 8, from bit 0 to bit 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high; clears the stored digit |
| digitIn | input | 4 | BCD digit; bit 0 has weight 1 |
| captureN | input | 1 | Active low: 0 = transparent and loading, 1 = hold |
| lampTestN | input | 1 | Active low: lights all segments |
| blankN | input | 1 | Active low: darkens all segments unless lamp test is active |
| segOut | output | 7 | Segment drives, active high; bit 0 = a through bit 6 = g |

## Verification
Every output path is combinational, so the live-digit decode and both overrides are due in the same cycle as their stimulus. The only registered result is the stored digit, which can be seen one rising edge after it is taken or cleared. The bench changes inputs on the falling edge and samples `segOut` one nanosecond later, well before the next rising edge. A same-cycle check therefore never sees the effect of a later edge. Hold and reset checks are made only after the loading edge has passed.

// File: rtl/bcd7_pkg.sv
package bcd7_pkg;

  localparam int DIGIT_W = 4;
  localparam int SEG_N   = 7;

  // Strobes sent from the control module to the datapath.
  typedef struct packed {
    logic loadDigit;  // take the live digit into the register
    logic selLive;    // decode the live digit instead of the stored one
    logic forceOn;    // light every segment
    logic forceOff;   // darken every segment
  } segCtrl_t;

endpackage

// File: rtl/bcd7_ctrl.sv
module bcd7_ctrl
  import bcd7_pkg::*;
(
  input  logic     captureN,
  input  logic     lampTestN,
  input  logic     blankN,
  output segCtrl_t strobes
);

  always_comb begin
    strobes.loadDigit = ~captureN;
    strobes.selLive   = ~captureN;
    // Lamp test has priority, so blanking is masked while it is active.
    strobes.forceOn   = ~lampTestN;
    strobes.forceOff  = lampTestN & ~blankN;
  end

endmodule

// File: rtl/bcd7_datapath.sv
module bcd7_datapath
  import bcd7_pkg::*;
#(
  parameter int DW = DIGIT_W,
  parameter int SN = SEG_N
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] digitIn,
  input  segCtrl_t      strobes,
  output logic [SN-1:0] segOut
);

  localparam logic [SN-1:0] ALL_ON  = {SN{1'b1}};
  localparam logic [SN-1:0] ALL_OFF = {SN{1'b0}};

  logic [DW-1:0] heldDigit;
  logic [DW-1:0] shownDigit;
  logic [SN-1:0] pattern;

  // Segment order inside a pattern is {g,f,e,d,c,b,a}.
  function automatic logic [SN-1:0] digitToSegs(input logic [DW-1:0] v);
    logic [SN-1:0] r;
    case (v)
      0:       r = 7'h3F;
      1:       r = 7'h06;
      2:       r = 7'h5B;
      3:       r = 7'h4F;
      4:       r = 7'h66;
      5:       r = 7'h6D;
      6:       r = 7'h7C;
      7:       r = 7'h07;
      8:       r = 7'h7F;
      9:       r = 7'h67;
      default: r = ALL_OFF;
    endcase
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (rst)                    heldDigit <= '0;
    else if (strobes.loadDigit) heldDigit <= digitIn;
  end

  assign shownDigit = strobes.selLive ? digitIn : heldDigit;
  assign pattern    = digitToSegs(shownDigit);

  // One override stage per segment.
  for (genvar s = 0; s < SN; s++) begin : g_seg
    assign segOut[s] = strobes.forceOn | (~strobes.forceOff & pattern[s]);
  end

  assert_reset_clears_R8: assert property (@(posedge clk)
    rst |=> heldDigit == '0);

  assert_capture_loads_R2: assert property (@(posedge clk) disable iff (rst)
    strobes.loadDigit |=> heldDigit == $past(digitIn));

  assert_hold_stable_R5: assert property (@(posedge clk) disable iff (rst)
    !strobes.loadDigit |=> $stable(heldDigit));

  assert_lamp_all_on_R3: assert property (@(posedge clk) disable iff (rst)
    strobes.forceOn |-> segOut == ALL_ON);

  assert_blank_all_off_R4: assert property (@(posedge clk) disable iff (rst)
    (strobes.forceOff && !strobes.forceOn) |-> segOut == ALL_OFF);

  assert_high_codes_dark_R6: assert property (@(posedge clk) disable iff (rst)
    (!strobes.forceOn && shownDigit > 9) |-> segOut == ALL_OFF);

endmodule

// File: rtl/bcd7_decoder.sv
module bcd7_decoder
  import bcd7_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [DIGIT_W-1:0] digitIn,
  input  logic               captureN,
  input  logic               lampTestN,
  input  logic               blankN,
  output logic [SEG_N-1:0]   segOut
);

  segCtrl_t strobes;

  bcd7_ctrl u_ctrl (
    .captureN  (captureN),
    .lampTestN (lampTestN),
    .blankN    (blankN),
    .strobes   (strobes)
  );

  bcd7_datapath #(.DW(DIGIT_W), .SN(SEG_N)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .digitIn (digitIn),
    .strobes (strobes),
    .segOut  (segOut)
  );

endmodule

// File: tb/bcd7_decoder_test.sv
`timescale 1ns/1ps
module bcd7_decoder_test;

  logic       clk = 1'b0;
  logic       rst;
  logic [3:0] digitIn;
  logic       captureN, lampTestN, blankN;
  logic [6:0] segOut;

  int vectors = 0;
  int misses  = 0;
  bit done    = 0;

  always #2.5 clk = ~clk;

  bcd7_decoder uut (
    .clk(clk), .rst(rst), .digitIn(digitIn), .captureN(captureN),
    .lampTestN(lampTestN), .blankN(blankN), .segOut(segOut)
  );

  // Per-segment masks: bit d is set when digit d lights that segment.
  function automatic logic [6:0] refSegs(input int d);
    logic [15:0] m [7];
    logic [6:0]  r;
    m[0] = 16'h03AD; m[1] = 16'h039F; m[2] = 16'h03FB; m[3] = 16'h016D;
    m[4] = 16'h0145; m[5] = 16'h0371; m[6] = 16'h037C;
    for (int s = 0; s < 7; s++) r[s] = m[s][d];
    return r;
  endfunction

  task automatic check(input string req, input logic [6:0] exp);
    vectors++;
    if (segOut !== exp) begin
      misses++;
      $display("FAIL %s: segOut=%h expected=%h (digitIn=%0d captureN=%b lt=%b bl=%b)",
               req, segOut, exp, digitIn, captureN, lampTestN, blankN);
    end
  endtask

  // Drive on the falling edge, then settle 1 ns.
  task automatic drive(input logic [3:0] d, input logic cn, input logic lt, input logic bl);
    @(negedge clk);
    digitIn = d; captureN = cn; lampTestN = lt; blankN = bl;
    #1;
  endtask

  initial begin
    rst = 1; digitIn = 4'd7; captureN = 1; lampTestN = 1; blankN = 1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0; #1;
    check("R8 reset digit zero", 7'h3F);

    // Transparent sweep of all codes, checked the same cycle.
    for (int d = 0; d < 16; d++) begin
      drive(d[3:0], 1'b0, 1'b1, 1'b1);
      if (d > 9) check("R6 high code dark", 7'h00);
      else       check("R1/R7/R9 live decode", refSegs(d));
    end

    // Take digit 5, then hold while the input sweeps.
    drive(4'd5, 1'b0, 1'b1, 1'b1);
    for (int d = 0; d < 16; d++) begin
      drive(d[3:0], 1'b1, 1'b1, 1'b1);
      check("R2 hold ignores input", refSegs(5));
    end

    // Take a new value, then take digit 3 and hold it.
    drive(4'd9, 1'b0, 1'b1, 1'b1);
    check("R1 live after release", refSegs(9));
    drive(4'd3, 1'b0, 1'b1, 1'b1);
    drive(4'd8, 1'b1, 1'b1, 1'b1);
    check("R2 held digit 3", refSegs(3));

    // Override combinations while holding.
    drive(4'd1, 1'b1, 1'b0, 1'b1);  check("R3 lamp test", 7'h7F);
    drive(4'd2, 1'b1, 1'b0, 1'b0);  check("R3 lamp over blank", 7'h7F);
    drive(4'd4, 1'b1, 1'b1, 1'b0);  check("R4 blank", 7'h00);
    drive(4'd6, 1'b1, 1'b1, 1'b1);  check("R5 held after overrides", refSegs(3));

    // Overrides while transparent still load the register.
    drive(4'd2, 1'b0, 1'b0, 1'b1);  check("R3 lamp live", 7'h7F);
    drive(4'd2, 1'b1, 1'b1, 1'b0);  check("R4 blank on held 2", 7'h00);
    drive(4'd0, 1'b1, 1'b1, 1'b1);  check("R5 held 2 shown", refSegs(2));
    drive(4'd12, 1'b0, 1'b1, 1'b0); check("R4 blank live", 7'h00);
    drive(4'd0, 1'b1, 1'b1, 1'b1);  check("R6 held 12 dark", 7'h00);

    // Reset during hold.
    drive(4'd9, 1'b0, 1'b1, 1'b1);
    @(negedge clk); captureN = 1; rst = 1;
    @(negedge clk); rst = 0; #1;
    check("R8 reset while holding", refSegs(0));

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      misses++;
      vectors++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

endmodule